// File: doc/BRIEF.md
# Fully Associative Translation Buffer With Fault Recording

This block translates 64-bit virtual addresses into 41-bit physical page addresses through a parameterised, fully associative set of entries (64 by default). Each entry holds a tag (virtual page number plus a 13-bit context) and a data word. The data word carries a valid bit, a page-size code, a global flag, access attributes and the physical page number. Entries are loaded through a write port by the miss handler. Lookups arrive on a request port and are answered one clock later with hit, physical address, read/write permission and a trap code.

Each lookup chooses a context. Data accesses pick the primary, secondary or nucleus (zero) context. Instruction fetches pick the primary context at trap level zero and context zero otherwise. When a matching entry refuses the access, the block records a fault status word, the faulting address and a tag-access word. The status word follows overflow rules when the previous fault has not been cleared. On a miss only the tag-access word is written. A successful hit marks the entry as used.

Top module: `tlbx_top`

## Requirements
- R1: After reset, rspValid is 0, faultStatus, faultAddr and tagAccess are 0, and usedMask is all zeros.
- R2: A lookup presented with lkValid=1 on a clock edge is answered with rspValid=1 after that edge. Data bits 62:61 select the page size (0: 8 KB, 1: 64 KB, 2: 512 KB, 3: 4 MB), and the size fixes the mask of virtual bits that are compared. rspPaddr is (data & mask) | (address & ~mask), keeping only bits 40:13, with bits 12:0 zero.
- R3: An entry matches only when data bit 63 (valid) is 1, tag bits 63:13 equal the address under the mask, and either data bit 0 (global) is 1 or tag bits 12:0 equal the selected context. With no match, rspHit=0 and rspTrap is 1 (data miss) or 4 (fetch miss).
- R4: lkOp encodes 0 load, 1 store, 2 no-fault load and 3 fetch. For data accesses, lkCtxSel 0 selects primaryCtx, 1 selects secondaryCtx and 2 or 3 selects context 0. faultStatus bits 5:4 record the choice as 0, 1 or 2 respectively.
- R5: A fetch uses primaryCtx when lkTrapLevelNz=0 and context 0 otherwise, recording 0 or 2 in faultStatus bits 5:4.
- R6: A user access (lkUser=1) to an entry with data bit 2 (privileged) set gives rspTrap 2 (data fault) or 5 (fetch fault) and sets faultStatus bit 7.
- R7: A no-fault load to an entry with data bit 4 (side effects) set sets faultStatus bit 8. Any other data access to an entry with data bit 60 (no-fault only) set sets faultStatus bit 9. These bits combine with bit 7 in one data fault. A no-fault load to a no-fault-only page does not fault.
- R8: A store to an entry with data bit 1 (writable) clear, and no R6 or R7 fault, gives rspTrap 3 (protection). If an R6 or R7 fault is also present, the trap is 2.
- R9: On any fault, faultStatus becomes: bit 0 = 1; bit 1 = the old bit 0 (overflow); bit 2 = store; bit 3 = !lkUser; bit 6 = no-fault load; bits 5:4 and 9:7 as above. faultAddr takes the address.
- R10: On a fault or a miss, tagAccess becomes the address with bits 12:0 replaced by the selected context. A miss leaves faultStatus and faultAddr unchanged.
- R11: A hit without fault sets usedMask for that entry and gives rspCanRead=1 and rspCanWrite equal to the writable bit. A faulting access sets neither permission and leaves the used bit alone.
- R12: When several entries match, the lowest-numbered one supplies the result and receives the used mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Load an entry |
| wrIdx | input | 6 | Entry index to load |
| wrTag | input | 64 | Tag: virtual page in 63:13, context in 12:0 |
| wrData | input | 64 | Entry data word |
| lkValid | input | 1 | Lookup request |
| lkAddr | input | 64 | Virtual address |
| lkOp | input | 2 | 0 load, 1 store, 2 no-fault load, 3 fetch |
| lkCtxSel | input | 2 | Data context: 0 primary, 1 secondary, 2/3 nucleus |
| lkUser | input | 1 | Access made in user mode |
| lkTrapLevelNz | input | 1 | Trap level is non-zero (fetch context) |
| primaryCtx | input | 13 | Primary context value |
| secondaryCtx | input | 13 | Secondary context value |
| rspValid | output | 1 | Response valid |
| rspHit | output | 1 | An entry matched |
| rspTrap | output | 3 | 0 none, 1 data miss, 2 data fault, 3 protection, 4 fetch miss, 5 fetch fault |
| rspPaddr | output | 41 | Physical page address |
| rspCanRead | output | 1 | Read permitted |
| rspCanWrite | output | 1 | Write permitted |
| faultStatus | output | 16 | Fault status word |
| faultAddr | output | 64 | Last faulting address |
| tagAccess | output | 64 | Last missing/faulting page and context |
| usedMask | output | 64 | Per-entry used flags |

## Verification
The assertions assume lkOp and lkCtxSel always hold one of their defined codes. They also assume that a protection trap can only follow a store presented on the previous edge, and that nothing clears the status valid bit except reset. The bench drives every lookup for exactly one cycle. It changes inputs only on falling edges and never loads and looks up the same entry in one cycle. Every value it drives therefore has a single defined outcome.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
  localparam int VA_W   = 64;
  localparam int CTX_W  = 13;
  localparam int STAT_W = 16;

  // data word field positions
  localparam int D_VALID = 63;
  localparam int D_SZ_HI = 62;
  localparam int D_SZ_LO = 61;
  localparam int D_NFO   = 60;
  localparam int D_SIDE  = 4;
  localparam int D_PRIV  = 2;
  localparam int D_WR    = 1;
  localparam int D_GLOB  = 0;

  // status word field positions
  localparam int S_VALID = 0;
  localparam int S_OVF   = 1;
  localparam int S_WRITE = 2;
  localparam int S_PRIVM = 3;
  localparam int S_NFACC = 6;
  localparam int S_FTPRV = 7;
  localparam int S_FTSE  = 8;
  localparam int S_FTNFO = 9;

  localparam logic [1:0] OP_LOAD = 2'd0;
  localparam logic [1:0] OP_STORE = 2'd1;
  localparam logic [1:0] OP_NFLOAD = 2'd2;
  localparam logic [1:0] OP_FETCH = 2'd3;

  typedef enum logic [2:0] {
    TRAP_NONE = 3'd0, TRAP_DMISS = 3'd1, TRAP_DFAULT = 3'd2,
    TRAP_DPROT = 3'd3, TRAP_IMISS = 3'd4, TRAP_IFAULT = 3'd5
  } trap_t;

  typedef struct packed {
    logic lookupEn;
    logic markUsed;
  } dpStrobe_t;

  function automatic logic [VA_W-1:0] sizeMask(input logic [1:0] sz);
    case (sz)
      2'd0: sizeMask = ~64'h0000_0000_0000_1FFF;
      2'd1: sizeMask = ~64'h0000_0000_0000_FFFF;
      2'd2: sizeMask = ~64'h0000_0000_0007_FFFF;
      default: sizeMask = ~64'h0000_0000_003F_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/tlbx_entries.sv
module tlbx_entries
  import tlbx_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [VA_W-1:0]    wrTag,
  input  logic [VA_W-1:0]    wrData,
  input  logic [VA_W-1:0]    lkAddr,
  input  logic [CTX_W-1:0]   lkCtx,
  input  dpStrobe_t          strobe,
  output logic               matchAny,
  output logic [IDX_W-1:0]   matchIdx,
  output logic [VA_W-1:0]    matchData,
  output logic [ENTRIES-1:0] usedMask
);
  logic [VA_W-1:0]    tagMem  [ENTRIES];
  logic [VA_W-1:0]    dataMem [ENTRIES];
  logic [ENTRIES-1:0] hitVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tagMem[i]  <= '0;
        dataMem[i] <= '0;
      end
    end else if (wrEn) begin
      tagMem[wrIdx]  <= wrTag;
      dataMem[wrIdx] <= wrData;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
    logic [VA_W-1:0] pageMask;
    logic            vaEq;
    logic            ctxEq;
    assign pageMask  = sizeMask(dataMem[g][D_SZ_HI:D_SZ_LO]);
    assign vaEq      = (lkAddr & pageMask) == (tagMem[g] & pageMask);
    assign ctxEq     = dataMem[g][D_GLOB] || (tagMem[g][CTX_W-1:0] == lkCtx);
    assign hitVec[g] = strobe.lookupEn && dataMem[g][D_VALID] && vaEq && ctxEq;
  end

  // lowest index wins
  always_comb begin
    matchIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) matchIdx = IDX_W'(i);
    end
  end

  assign matchAny  = |hitVec;
  assign matchData = dataMem[matchIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      usedMask <= '0;
    end else begin
      if (strobe.markUsed) usedMask[matchIdx] <= 1'b1;
      if (wrEn) usedMask[wrIdx] <= 1'b0;
    end
  end
endmodule

// File: rtl/tlbx_control.sv
module tlbx_control
  import tlbx_pkg::*;
#(
  parameter int PA_W = 41
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  input  logic [VA_W-1:0]   lkAddr,
  input  logic [1:0]        lkOp,
  input  logic [1:0]        lkCtxSel,
  input  logic              lkUser,
  input  logic              lkTrapLevelNz,
  input  logic [CTX_W-1:0]  primaryCtx,
  input  logic [CTX_W-1:0]  secondaryCtx,
  input  logic              matchAny,
  input  logic [VA_W-1:0]   matchData,
  output logic [CTX_W-1:0]  lkCtx,
  output dpStrobe_t         strobe,
  output logic              rspValid,
  output logic              rspHit,
  output logic [2:0]        rspTrap,
  output logic [PA_W-1:0]   rspPaddr,
  output logic              rspCanRead,
  output logic              rspCanWrite,
  output logic [STAT_W-1:0] faultStatus,
  output logic [VA_W-1:0]   faultAddr,
  output logic [VA_W-1:0]   tagAccess
);
  localparam logic [VA_W-1:0] PA_KEEP = ((VA_W'(1) << PA_W) - 1) & ~VA_W'(64'h1FFF);

  logic            isFetch, ftPriv, ftSide, ftNfo, accFault, protFault, anyFault;
  logic [1:0]      ctxType;
  logic [VA_W-1:0] pageMask, paFull;
  logic [STAT_W-1:0] nextStatus;
  trap_t           trapNext;

  assign isFetch = (lkOp == OP_FETCH);

  always_comb begin
    if (isFetch) begin
      lkCtx   = lkTrapLevelNz ? '0 : primaryCtx;
      ctxType = lkTrapLevelNz ? 2'd2 : 2'd0;
    end else begin
      case (lkCtxSel)
        2'd0:    begin lkCtx = primaryCtx;   ctxType = 2'd0; end
        2'd1:    begin lkCtx = secondaryCtx; ctxType = 2'd1; end
        default: begin lkCtx = '0;           ctxType = 2'd2; end
      endcase
    end
  end

  assign ftPriv    = matchData[D_PRIV] && lkUser;
  assign ftSide    = !isFetch && (lkOp == OP_NFLOAD) && matchData[D_SIDE];
  assign ftNfo     = !isFetch && (lkOp != OP_NFLOAD) && matchData[D_NFO];
  assign accFault  = matchAny && (ftPriv || ftSide || ftNfo);
  assign protFault = matchAny && !accFault && (lkOp == OP_STORE) && !matchData[D_WR];
  assign anyFault  = accFault || protFault;

  always_comb begin
    if (!matchAny)     trapNext = isFetch ? TRAP_IMISS : TRAP_DMISS;
    else if (accFault) trapNext = isFetch ? TRAP_IFAULT : TRAP_DFAULT;
    else if (protFault) trapNext = TRAP_DPROT;
    else               trapNext = TRAP_NONE;
  end

  assign pageMask = sizeMask(matchData[D_SZ_HI:D_SZ_LO]);
  assign paFull   = ((matchData & pageMask) | (lkAddr & ~pageMask)) & PA_KEEP;

  always_comb begin
    nextStatus          = '0;
    nextStatus[S_VALID] = 1'b1;
    nextStatus[S_OVF]   = faultStatus[S_VALID];
    nextStatus[S_WRITE] = (lkOp == OP_STORE);
    nextStatus[S_PRIVM] = !lkUser;
    nextStatus[5:4]     = ctxType;
    nextStatus[S_NFACC] = (lkOp == OP_NFLOAD);
    nextStatus[S_FTPRV] = ftPriv;
    nextStatus[S_FTSE]  = ftSide;
    nextStatus[S_FTNFO] = ftNfo;
  end

  assign strobe.lookupEn = lkValid;
  assign strobe.markUsed = lkValid && matchAny && !anyFault;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspHit      <= 1'b0;
      rspTrap     <= TRAP_NONE;
      rspPaddr    <= '0;
      rspCanRead  <= 1'b0;
      rspCanWrite <= 1'b0;
      faultStatus <= '0;
      faultAddr   <= '0;
      tagAccess   <= '0;
    end else begin
      rspValid <= lkValid;
      if (lkValid) begin
        rspHit      <= matchAny;
        rspTrap     <= trapNext;
        rspPaddr    <= paFull[PA_W-1:0];
        rspCanRead  <= matchAny && !anyFault;
        rspCanWrite <= matchAny && !anyFault && matchData[D_WR];
        if (anyFault) begin
          faultStatus <= nextStatus;
          faultAddr   <= lkAddr;
        end
        if (anyFault || !matchAny) tagAccess <= {lkAddr[VA_W-1:CTX_W], lkCtx};
      end
    end
  end
endmodule

// File: rtl/tlbx_top.sv
module tlbx_top
  import tlbx_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int PA_W    = 41
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [$clog2(ENTRIES)-1:0] wrIdx,
  input  logic [63:0]                wrTag,
  input  logic [63:0]                wrData,
  input  logic                       lkValid,
  input  logic [63:0]                lkAddr,
  input  logic [1:0]                 lkOp,
  input  logic [1:0]                 lkCtxSel,
  input  logic                       lkUser,
  input  logic                       lkTrapLevelNz,
  input  logic [12:0]                primaryCtx,
  input  logic [12:0]                secondaryCtx,
  output logic                       rspValid,
  output logic                       rspHit,
  output logic [2:0]                 rspTrap,
  output logic [PA_W-1:0]            rspPaddr,
  output logic                       rspCanRead,
  output logic                       rspCanWrite,
  output logic [15:0]                faultStatus,
  output logic [63:0]                faultAddr,
  output logic [63:0]                tagAccess,
  output logic [ENTRIES-1:0]         usedMask
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [CTX_W-1:0] lkCtx;
  dpStrobe_t        strobe;
  logic             matchAny;
  logic [IDX_W-1:0] matchIdx;
  logic [VA_W-1:0]  matchData;
  logic             unusedIdx;

  assign unusedIdx = ^matchIdx;

  tlbx_entries #(.ENTRIES(ENTRIES)) uEntries (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrTag(wrTag),
    .wrData(wrData), .lkAddr(lkAddr), .lkCtx(lkCtx), .strobe(strobe),
    .matchAny(matchAny), .matchIdx(matchIdx), .matchData(matchData),
    .usedMask(usedMask)
  );

  tlbx_control #(.PA_W(PA_W)) uControl (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkAddr(lkAddr), .lkOp(lkOp),
    .lkCtxSel(lkCtxSel), .lkUser(lkUser), .lkTrapLevelNz(lkTrapLevelNz),
    .primaryCtx(primaryCtx), .secondaryCtx(secondaryCtx),
    .matchAny(matchAny), .matchData(matchData), .lkCtx(lkCtx),
    .strobe(strobe), .rspValid(rspValid), .rspHit(rspHit),
    .rspTrap(rspTrap), .rspPaddr(rspPaddr), .rspCanRead(rspCanRead),
    .rspCanWrite(rspCanWrite), .faultStatus(faultStatus),
    .faultAddr(faultAddr), .tagAccess(tagAccess)
  );
endmodule

// File: rtl/tlbx_checker.sv
module tlbx_checker (
  input logic        clk,
  input logic        rstN,
  input logic        lkValid,
  input logic [1:0]  lkOp,
  input logic        rspValid,
  input logic        rspHit,
  input logic [2:0]  rspTrap,
  input logic        rspCanRead,
  input logic        rspCanWrite,
  input logic [15:0] faultStatus
);
  a_r2_rsp_after_req: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(lkValid));

  a_r3_miss_no_hit: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && (rspTrap == 3'd1 || rspTrap == 3'd4)) |-> !rspHit);

  a_r11_write_needs_read: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspCanWrite) |-> rspCanRead);

  a_r6_fault_denies_access: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && (rspTrap == 3'd2 || rspTrap == 3'd3 || rspTrap == 3'd5))
      |-> (rspHit && !rspCanRead && !rspCanWrite));

  a_r8_prot_from_store: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspTrap == 3'd3) |-> ($past(lkOp) == 2'd1));

  a_r9_valid_sticky: assert property (@(posedge clk) disable iff (!rstN)
    faultStatus[0] |=> faultStatus[0]);

  a_r9_overflow_after_valid: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultStatus[1]) |-> $past(faultStatus[0]));
endmodule

bind tlbx_top tlbx_checker uChecker (
  .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkOp(lkOp),
  .rspValid(rspValid), .rspHit(rspHit), .rspTrap(rspTrap),
  .rspCanRead(rspCanRead), .rspCanWrite(rspCanWrite),
  .faultStatus(faultStatus)
);

// File: tb/sim_tlbx_top.sv
module sim_tlbx_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  wrIdx = '0;
  logic [63:0] wrTag = '0, wrData = '0;
  logic        lkValid = 1'b0;
  logic [63:0] lkAddr = '0;
  logic [1:0]  lkOp = '0, lkCtxSel = '0;
  logic        lkUser = 1'b0, lkTrapLevelNz = 1'b0;
  logic [12:0] primaryCtx = 13'h05, secondaryCtx = 13'h09;
  logic        rspValid, rspHit, rspCanRead, rspCanWrite;
  logic [2:0]  rspTrap;
  logic [40:0] rspPaddr;
  logic [15:0] faultStatus;
  logic [63:0] faultAddr, tagAccess, usedMask;

  int nChk = 0;
  int nFail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  tlbx_top u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrTag(wrTag),
    .wrData(wrData), .lkValid(lkValid), .lkAddr(lkAddr), .lkOp(lkOp),
    .lkCtxSel(lkCtxSel), .lkUser(lkUser), .lkTrapLevelNz(lkTrapLevelNz),
    .primaryCtx(primaryCtx), .secondaryCtx(secondaryCtx),
    .rspValid(rspValid), .rspHit(rspHit), .rspTrap(rspTrap),
    .rspPaddr(rspPaddr), .rspCanRead(rspCanRead), .rspCanWrite(rspCanWrite),
    .faultStatus(faultStatus), .faultAddr(faultAddr), .tagAccess(tagAccess),
    .usedMask(usedMask)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mkData(input logic [1:0] sz, input logic [63:0] pa,
      input logic nfo, input logic side, input logic priv, input logic wr,
      input logic glob, input logic vld = 1'b1);
    logic [63:0] d;
    d = pa & 64'h0000_01FF_FFFF_E000;
    d[63] = vld; d[62:61] = sz; d[60] = nfo; d[4] = side;
    d[2] = priv; d[1] = wr; d[0] = glob;
    return d;
  endfunction

  task automatic load(input int idx, input logic [63:0] tag, input logic [63:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 6'(idx); wrTag = tag; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // response registered at the edge between the two falling edges
  task automatic lookup(input logic [63:0] a, input logic [1:0] op,
                        input logic [1:0] sel, input logic usr, input logic tl);
    @(negedge clk);
    lkValid = 1'b1; lkAddr = a; lkOp = op; lkCtxSel = sel;
    lkUser = usr; lkTrapLevelNz = tl;
    @(negedge clk);
    lkValid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "rspValid", 64'(rspValid), 0);
    chk("R1", "status", 64'(faultStatus), 0);
    chk("R1", "faultAddr", faultAddr, 0);
    chk("R1", "tagAccess", tagAccess, 0);
    chk("R1", "usedMask", usedMask, 0);
  endtask

  task automatic t_sizes();
    load(0, 64'h0000_0000_0040_0005, mkData(2'd0, 64'h12_3456_6000, 0, 0, 0, 1, 0));
    lookup(64'h0000_0000_0040_0123, 2'd0, 2'd0, 1'b1, 1'b0);
    chk("R2", "rspValid", 64'(rspValid), 1);
    chk("R2", "8K pa", 64'(rspPaddr), 64'h12_3456_6000);
    chk("R11", "8K rd/wr/trap", {61'(rspTrap), rspCanRead, rspCanWrite, rspHit}, 64'h7);
    chk("R11", "used0", 64'(usedMask[0]), 1);
    // 4M global page, entry context 7, accessed with secondary context 9
    load(1, 64'h0000_0001_0000_0007, mkData(2'd3, 64'h40_0000_0000, 0, 0, 0, 0, 1));
    lookup(64'h0000_0001_0012_3456, 2'd0, 2'd1, 1'b0, 1'b0);
    chk("R3", "global hit", 64'(rspHit), 1);
    chk("R2", "4M pa", 64'(rspPaddr), 64'h40_0012_2000);
    chk("R11", "ro canWrite", 64'(rspCanWrite), 0);
    chk("R11", "ro canRead", 64'(rspCanRead), 1);
    // 64K page, context 9
    load(2, 64'h0000_0002_0000_0009, mkData(2'd1, 64'h3_0000_0000, 0, 0, 0, 1, 0));
    lookup(64'h0000_0002_0000_ABCD, 2'd1, 2'd1, 1'b1, 1'b0);
    chk("R4", "secondary hit", 64'(rspHit), 1);
    chk("R2", "64K pa", 64'(rspPaddr), 64'h3_0000_A000);
  endtask

  task automatic t_miss();
    lookup(64'h0000_0002_0000_ABCD, 2'd0, 2'd0, 1'b1, 1'b0);
    chk("R3", "ctx mismatch trap", 64'(rspTrap), 1);
    chk("R3", "ctx mismatch hit", 64'(rspHit), 0);
    chk("R10", "miss tagAccess", tagAccess, 64'h0000_0002_0000_A005);
    chk("R10", "miss status kept", 64'(faultStatus), 0);
    chk("R10", "miss faultAddr kept", faultAddr, 0);
    load(11, 64'h0000_0009_0000_0005, mkData(2'd0, 64'h1000_0000, 0, 0, 0, 1, 0, 1'b0));
    lookup(64'h0000_0009_0000_0010, 2'd0, 2'd0, 1'b0, 1'b0);
    chk("R3", "invalid entry miss", 64'(rspTrap), 1);
  endtask

  task automatic t_priv();
    load(3, 64'h0000_0003_0008_0000, mkData(2'd2, 64'h5_0000_0000, 0, 0, 1, 0, 0));
    lookup(64'h0000_0003_000F_FFF8, 2'd0, 2'd2, 1'b0, 1'b0);
    chk("R4", "nucleus hit", 64'(rspHit), 1);
    chk("R2", "512K pa", 64'(rspPaddr), 64'h5_0007_E000);
    chk("R11", "used3", 64'(usedMask[3]), 1);
    lookup(64'h0000_0003_000F_FFF8, 2'd0, 2'd2, 1'b1, 1'b0);
    chk("R6", "priv trap", 64'(rspTrap), 2);
    chk("R6", "priv status", 64'(faultStatus), 64'h0A1);
    chk("R9", "faultAddr", faultAddr, 64'h0000_0003_000F_FFF8);
    chk("R10", "fault tagAccess", tagAccess, 64'h0000_0003_000F_E000);
  endtask

  task automatic t_fetch();
    load(4, 64'h0000_0004_0000_0005, mkData(2'd0, 64'h6_0000_0000, 0, 0, 0, 0, 0));
    lookup(64'h0000_0004_0000_0100, 2'd3, 2'd1, 1'b1, 1'b0);
    chk("R5", "fetch tl0 hit", 64'(rspHit), 1);
    chk("R5", "fetch pa", 64'(rspPaddr), 64'h6_0000_0000);
    lookup(64'h0000_0004_0000_0100, 2'd3, 2'd1, 1'b1, 1'b1);
    chk("R5", "fetch tl1 trap", 64'(rspTrap), 4);
    chk("R10", "fetch tagAccess", tagAccess, 64'h0000_0004_0000_0000);
    load(5, 64'h0000_0005_0000_0000, mkData(2'd0, 64'h7_0000_0000, 0, 0, 1, 0, 0));
    lookup(64'h0000_0005_0000_0040, 2'd3, 2'd0, 1'b1, 1'b1);
    chk("R6", "fetch fault trap", 64'(rspTrap), 5);
    chk("R9", "overflow status", 64'(faultStatus), 64'h0A3);
  endtask

  task automatic t_attrs();
    load(6, 64'h0000_0006_0000_0005, mkData(2'd0, 64'h8_0000_0000, 0, 1, 0, 1, 0));
    lookup(64'h0000_0006_0000_0008, 2'd2, 2'd0, 1'b0, 1'b0);
    chk("R7", "nf side trap", 64'(rspTrap), 2);
    chk("R7", "nf side status", 64'(faultStatus), 64'h14B);
    lookup(64'h0000_0006_0000_0008, 2'd0, 2'd0, 1'b0, 1'b0);
    chk("R7", "normal side ok", 64'(rspTrap), 0);
    load(7, 64'h0000_0007_0000_0005, mkData(2'd0, 64'h9_0000_0000, 1, 0, 1, 0, 0));
    lookup(64'h0000_0007_0000_0000, 2'd0, 2'd0, 1'b1, 1'b0);
    chk("R7", "nfo+priv status", 64'(faultStatus), 64'h283);
    chk("R11", "fault no used", 64'(usedMask[7]), 0);
    lookup(64'h0000_0007_0000_0000, 2'd2, 2'd0, 1'b0, 1'b0);
    chk("R7", "nf on nfo ok", 64'(rspTrap), 0);
    chk("R11", "used7", 64'(usedMask[7]), 1);
  endtask

  task automatic t_prot();
    lookup(64'h0000_0001_0000_0000, 2'd1, 2'd0, 1'b0, 1'b0);
    chk("R8", "prot trap", 64'(rspTrap), 3);
    chk("R8", "prot status", 64'(faultStatus), 64'h00F);
    chk("R9", "prot faultAddr", faultAddr, 64'h0000_0001_0000_0000);
    lookup(64'h0000_0003_0008_0000, 2'd1, 2'd3, 1'b1, 1'b0);
    chk("R8", "priv beats prot", 64'(rspTrap), 2);
    chk("R8", "priv store status", 64'(faultStatus), 64'h0A7);
  endtask

  task automatic t_priority();
    load(20, 64'h0000_0008_0000_0005, mkData(2'd0, 64'hB_0000_0000, 0, 0, 0, 1, 0));
    load(10, 64'h0000_0008_0000_0005, mkData(2'd0, 64'hA_0000_0000, 0, 0, 0, 1, 0));
    lookup(64'h0000_0008_0000_0000, 2'd0, 2'd0, 1'b0, 1'b0);
    chk("R12", "lowest pa", 64'(rspPaddr), 64'hA_0000_0000);
    chk("R12", "used10/20", {62'd0, usedMask[20], usedMask[10]}, 64'h1);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_sizes();
    t_miss();
    t_priv();
    t_fetch();
    t_attrs();
    t_prot();
    t_priority();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule